// File: doc/BRIEF.md
# Two-Register 8-bit Accumulator Processor

A small multi-cycle processor core. It holds two 8-bit working registers (A and B), a 16-bit program counter and three condition flags: zero, sign and signed overflow. The core drives a single-port synchronous byte memory. Read data returns one cycle after the address is presented, and a write takes effect on the clock edge while the write enable is high.

Each instruction starts with a one-byte opcode. The opcode is followed by no operand, by an 8-bit constant, or by a 16-bit address. The core reads those bytes one per cycle and then executes the instruction. The instructions cover:
- moves between the registers and memory
- loading a constant
- swapping the two registers
- adding B into A
- negating a register
- signed compares
- conditional and unconditional jumps

Any opcode outside the defined set stops the core for good and raises an illegal-opcode output. The core stays stopped until reset.

Top module: `acc8_core`

## Requirements
- R1: While reset is asserted and after it, A, B and all flags are zero. The first fetch comes from address 0x0000 with the write enable low.
- R2: Opcode lengths are as follows. 0x03, 0x06, 0x0C and 0x0D take one constant byte. 0x07 through 0x0B take no operand. 0x01, 0x02, 0x04, 0x05 and 0x0E through 0x11 take a 16-bit address. After a non-jumping instruction the program counter moves past all of the instruction's bytes.
- R3: A 16-bit operand is read high byte first (lower address), then low byte.
- R4: 0x01 and 0x04 write A and B to memory. 0x02 and 0x05 load A and B from memory. 0x03 and 0x06 load A and B with a constant. 0x07 swaps A and B.
- R5: 0x08 sets A to A+B modulo 256. 0x09 and 0x0A replace A and B with their two's complement. 0x80 negates to 0x80 and sets overflow.
- R6: The compares are 0x0B (A with B), 0x0C (A with constant) and 0x0D (B with constant). Each one sets the flags from a signed subtraction, first minus second, and discards the result, so no register changes.
- R7: A taken jump loads the program counter with its operand. 0x0E jumps when zero is set. 0x0F jumps when sign equals overflow and zero is clear. 0x10 jumps when sign differs from overflow. 0x11 always jumps.
- R8: Only add, negate and the compares change the flags. Loads, stores, constants, swaps and jumps leave them unchanged.
- R9: Opcode 0x00 or any opcode above 0x11 sets the illegal-opcode output. After that the core writes nothing, holds its address and stays halted until reset.
- R10: A store holds the write enable high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |
| bad_op | output | 1 | Illegal opcode seen; core halted |

## Verification
The flags cannot be read out directly. Their only effect is which way a jump goes, so every flag case is checked through the stores that follow a jump. A taken jump skips a decoy store that would write to 0x03FF. A jump that should fall through targets a region of zero bytes, which halts the core early and loses the stores still expected. The hardest cases are the signed corners: comparing 0x80 with 0x01, where the subtraction overflows, and negating 0x80. Short constant loads reach them, and a scoreboard checks every store the program makes, in order, by address and data.

// File: rtl/acc8_core.sv
module acc8_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic        bad_op
);
  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OP1, S_OP2, S_MEM, S_LD, S_HALT} state_t;

  state_t      st;
  logic [15:0] pc, ea;
  logic [7:0]  a, b, ir, hi;
  logic        fz, fs, fv;

  logic [7:0]  sum, neg_a, neg_b, cmp_x, cmp_y, diff;
  logic [15:0] target;
  logic        len1, len2, len3;
  logic        is_store;

  assign sum    = a + b;
  assign neg_a  = 8'd0 - a;
  assign neg_b  = 8'd0 - b;
  assign cmp_x  = (st == S_OP1 && ir == 8'h0D) ? b : a;
  assign cmp_y  = (st == S_OP1) ? mem_rdata : b;
  assign diff   = cmp_x - cmp_y;
  assign target = {hi, mem_rdata};

  assign len1 = mem_rdata >= 8'h07 && mem_rdata <= 8'h0B;
  assign len2 = mem_rdata == 8'h03 || mem_rdata == 8'h06 ||
                mem_rdata == 8'h0C || mem_rdata == 8'h0D;
  assign len3 = mem_rdata == 8'h01 || mem_rdata == 8'h02 ||
                mem_rdata == 8'h04 || mem_rdata == 8'h05 ||
                (mem_rdata >= 8'h0E && mem_rdata <= 8'h11);

  assign is_store  = ir == 8'h01 || ir == 8'h04;
  assign mem_we    = st == S_MEM && is_store;
  assign mem_wdata = ir == 8'h01 ? a : b;
  assign bad_op    = st == S_HALT;

  always_comb begin
    case (st)
      S_DEC:        mem_addr = pc + 16'd1;
      S_OP1:        mem_addr = pc + 16'd2;
      S_MEM, S_LD:  mem_addr = ea;
      default:      mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH;
      pc <= '0;
      ea <= '0;
      a  <= '0;
      b  <= '0;
      ir <= '0;
      hi <= '0;
      fz <= 1'b0;
      fs <= 1'b0;
      fv <= 1'b0;
    end else begin
      case (st)
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          ir <= mem_rdata;
          if (len1) begin
            pc <= pc + 16'd1;
            st <= S_FETCH;
            case (mem_rdata)
              8'h07: begin a <= b; b <= a; end
              8'h08: begin
                a <= sum;
                fz <= sum == 8'd0;
                fs <= sum[7];
                fv <= (a[7] == b[7]) && (sum[7] != a[7]);
              end
              8'h09: begin
                a <= neg_a;
                fz <= neg_a == 8'd0;
                fs <= neg_a[7];
                fv <= a == 8'h80;
              end
              8'h0A: begin
                b <= neg_b;
                fz <= neg_b == 8'd0;
                fs <= neg_b[7];
                fv <= b == 8'h80;
              end
              default: begin
                fz <= diff == 8'd0;
                fs <= diff[7];
                fv <= (cmp_x[7] != cmp_y[7]) && (diff[7] != cmp_x[7]);
              end
            endcase
          end else if (len2 || len3) begin
            st <= S_OP1;
          end else begin
            st <= S_HALT;
          end
        end
        S_OP1: begin
          case (ir)
            8'h03: begin a <= mem_rdata; pc <= pc + 16'd2; st <= S_FETCH; end
            8'h06: begin b <= mem_rdata; pc <= pc + 16'd2; st <= S_FETCH; end
            8'h0C, 8'h0D: begin
              fz <= diff == 8'd0;
              fs <= diff[7];
              fv <= (cmp_x[7] != cmp_y[7]) && (diff[7] != cmp_x[7]);
              pc <= pc + 16'd2;
              st <= S_FETCH;
            end
            default: begin hi <= mem_rdata; st <= S_OP2; end
          endcase
        end
        S_OP2: begin
          case (ir)
            8'h0E: begin pc <= fz ? target : pc + 16'd3; st <= S_FETCH; end
            8'h0F: begin pc <= (fs == fv && !fz) ? target : pc + 16'd3; st <= S_FETCH; end
            8'h10: begin pc <= (fs != fv) ? target : pc + 16'd3; st <= S_FETCH; end
            8'h11: begin pc <= target; st <= S_FETCH; end
            default: begin ea <= target; st <= S_MEM; end
          endcase
        end
        S_MEM: begin
          if (is_store) begin
            pc <= pc + 16'd3;
            st <= S_FETCH;
          end else begin
            st <= S_LD;
          end
        end
        S_LD: begin
          if (ir == 8'h02) a <= mem_rdata;
          else b <= mem_rdata;
          pc <= pc + 16'd3;
          st <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        bad_op
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) bad_op |=> bad_op); // R9
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bad_op |-> !mem_we); // R9
  AST_HALT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) bad_op |=> $stable(mem_addr)); // R9
  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R10
endmodule

bind acc8_core acc8_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we), .bad_op(bad_op)
);

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        bad_op;

  always #2 clk = ~clk;

  acc8_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .bad_op(bad_op)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  typedef struct {logic [15:0] addr; logic [7:0] data; string req;} item_t;
  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int ptr    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q.size() == 0) begin
        check(1'b0, (mem_addr == 16'h03FF) ? "R7" : "R9", "unexpected write addr",
              {16'h0, mem_addr}, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(mem_addr == it.addr && mem_wdata == it.data, it.req, "store addr/data",
              {8'h0, mem_addr, mem_wdata}, {8'h0, it.addr, it.data});
      end
    end
  end

  task automatic expect_st(input logic [15:0] addr, input logic [7:0] data, input string req);
    item_t it;
    it.addr = addr; it.data = data; it.req = req;
    q.push_back(it);
  endtask

  task automatic emit(input logic [7:0] v);
    mem[ptr] = v;
    ptr++;
  endtask
  task automatic op1(input logic [7:0] o); emit(o); endtask
  task automatic op2(input logic [7:0] o, input logic [7:0] k); emit(o); emit(k); endtask
  task automatic op3(input logic [7:0] o, input logic [15:0] ad);
    emit(o); emit(ad[15:8]); emit(ad[7:0]);
  endtask
  task automatic jump_taken(input logic [7:0] o);
    op3(o, 16'(ptr + 6));
    op3(8'h01, 16'h03FF);
  endtask
  task automatic jump_not(input logic [7:0] o); op3(o, 16'h0200); endtask
  task automatic stor(input logic [7:0] o, input logic [15:0] ad, input logic [7:0] v,
                      input string req);
    op3(o, ad);
    expect_st(ad, v, req);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ptr = 0;
  endtask

  task automatic run_prog();
    logic [15:0] held;
    bit done;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_addr == 16'h0000 && !mem_we && !bad_op, "R1", "reset outputs",
          {15'h0, mem_we, mem_addr}, 32'h0);
    rst_n = 1'b1;
    done = 1'b0;
    for (int c = 0; c < 4000 && !done; c++) begin
      @(negedge clk);
      if (bad_op) done = 1'b1;
    end
    check(done, "R9", "halt reached (watchdog)", {31'h0, done}, 32'h1);
    held = mem_addr;
    repeat (6) @(negedge clk);
    check(bad_op && mem_addr == held, "R9", "halt held", {15'h0, bad_op, mem_addr},
          {15'h0, 1'b1, held});
    check(q.size() == 0, "R2", "pending stores", q.size(), 0);
    q.delete();
  endtask

  initial begin
    clear_mem();
    stor(8'h01, 16'h0300, 8'h00, "R1");
    stor(8'h04, 16'h0301, 8'h00, "R1");
    jump_not(8'h0E);
    jump_not(8'h10);
    jump_taken(8'h0F);                                  // R1 flags clear
    op2(8'h03, 8'h25);
    op2(8'h06, 8'h53);
    stor(8'h01, 16'h0302, 8'h25, "R4");
    op1(8'h07);
    stor(8'h01, 16'h0303, 8'h53, "R4");
    stor(8'h04, 16'h0304, 8'h25, "R4");
    op1(8'h08);
    stor(8'h01, 16'h0305, 8'h78, "R5");
    op3(8'h05, 16'h0305);
    op1(8'h0A);
    stor(8'h04, 16'h0306, 8'h88, "R5");
    op2(8'h03, 8'h80);
    op1(8'h09);
    stor(8'h01, 16'h0307, 8'h80, "R5");
    jump_not(8'h10);
    jump_taken(8'h0F);                                  // R5 overflow on 0x80
    op2(8'h03, 8'h00);
    op2(8'h0C, 8'hFF);
    jump_taken(8'h0F);                                  // R6 0 > -1
    jump_not(8'h10);
    jump_not(8'h0E);
    op2(8'h03, 8'h80);
    op2(8'h0C, 8'h01);
    jump_not(8'h0F);
    jump_taken(8'h10);                                  // R6 -128 < 1 with overflow
    op2(8'h06, 8'h7F);
    op1(8'h0B);
    jump_taken(8'h10);                                  // R7
    op2(8'h0D, 8'h7F);
    jump_taken(8'h0E);
    jump_not(8'h0F);
    jump_not(8'h10);
    op2(8'h03, 8'h80);
    op1(8'h07);
    op1(8'h07);
    jump_taken(8'h0E);                                  // R8 flags kept
    jump_taken(8'h11);
    stor(8'h01, 16'h0308, 8'h80, "R6");
    stor(8'h04, 16'h0309, 8'h7F, "R6");
    op3(8'h02, 16'h0302);
    stor(8'h01, 16'h0312, 8'h25, "R3");
    op1(8'h00);
    run_prog();

    clear_mem();
    op2(8'h03, 8'h01);
    stor(8'h01, 16'h0300, 8'h01, "R2");
    op1(8'h12);
    op2(8'h03, 8'h02);
    op3(8'h01, 16'h0301);
    run_prog();

    clear_mem();
    op1(8'hFF);
    op3(8'h01, 16'h0300);
    run_prog();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule